// File: doc/BRIEF.md
# User-Mode Access Permission Checker

This block sits beside the CPU bus and judges every access before it reaches memory. Each access brings four things: a 24-bit address, a write flag, the supervisor bit from the CPU status word, and the 16-bit page-map word for the addressed page. The block gives back a verdict. The access is either allowed or it raises a bus error. A bus error comes with a cause code, and for two of the causes the block also loads a 16-bit general-status word that fault-handling software reads to find out what went wrong. When a read faults, the data returned is forced to all ones.

In supervisor mode every access passes. In user mode the causes are checked in a fixed order, and the first one that applies is the verdict:

1. The address lies above the memory window.
2. The page is not present.
3. The address falls in the kernel region.
4. The page is not write-enabled.

A not-present fault and an out-of-window fault each load a status code, and the code differs for reads and writes. A kernel fault and a write-protect fault leave the status word alone. The verdict, the bus-error pulse, the status word and the returned read data are all registered, so they appear one clock after the access. A parameter selects whether the write-enable check also applies to reads (the default) or only to writes.

Top module: `access_guard`

## Requirements
- R1: When `cpu_super` is 1, the access is allowed for any address and map word: `verdict` 0, no `bus_err` pulse, `gen_status` unchanged.
- R2: A user access with any address bit at or above bit 22 set (address >= 0x400000) gives verdict 4 (outside the memory window). This cause takes precedence over every other cause.
- R3: For a user access below 0x400000, if map-word bits [14:13] are both 0, the verdict is 1 (page absent). This cause takes precedence over the kernel and write-enable causes.
- R4: For a user access below 0x400000 to a present page, if address bits [22:19] are all 0, the verdict is 3 (kernel region). This cause takes precedence over the write-enable cause.
- R5: For a user access that passes the earlier checks, if map-word bit 15 is 0, the verdict is 2 (write-protected). This applies to writes always. It applies to reads only when `WP_CHECKS_READS` is 1; with 0, such a read gets verdict 0.
- R6: A verdict of 1 loads `gen_status` with 0x8FFF for a write and 0xCFFF for a read.
- R7: A verdict of 4 loads `gen_status` with 0x9EFF for a write and 0xDEFF for a read.
- R8: Verdicts 0, 2 and 3 leave `gen_status` unchanged.
- R9: All outputs are registered and reflect the access one clock after it is presented. `bus_err` is high for exactly that one cycle, and only when the verdict is non-zero.
- R10: For a read with a non-zero verdict, `rd_data_out` is all ones. For an allowed read it equals `rd_data_in`. Writes leave `rd_data_out` unchanged.
- R11: After synchronous reset, `bus_err` is 0, `verdict` is 0, `gen_status` is 0xFFFF and `rd_data_out` is 0.
- R12: A cycle with `acc_valid` low gives `verdict` 0 and no `bus_err` pulse, and leaves `gen_status` and `rd_data_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Access address before translation |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| cpu_super | input | 1 | Supervisor bit of the CPU status word |
| map_entry | input | 16 | Page-map word for the addressed page (bit 15 write enable, bits 14:13 presence) |
| rd_data_in | input | 32 | Read data from memory |
| bus_err | output | 1 | One-cycle bus-error pulse |
| verdict | output | 3 | 0 allowed, 1 absent, 2 write-protected, 3 kernel, 4 outside window |
| gen_status | output | 16 | General-status word |
| rd_data_out | output | 32 | Read data returned to the CPU, all ones on a faulted read |

## Verification
The bench builds two copies of the block side by side with the same stimulus. One uses the default `WP_CHECKS_READS` = 1 and the other uses 0. A read from a present, non-kernel page that is not write-enabled must therefore fault in one copy and pass in the other. This exposes the variant choice and the write-flag dependence of the last check. The directed cases cover the 0x3FFFFF/0x400000 boundary, pages that meet several causes at once (to fix the priority order), and the read and write codes for each status-loading cause. A randomized run over a small set of addresses and map words then compares the two copies against a behavioural model on every cycle.

// File: rtl/access_guard_pkg.sv
// Package: shared verdict type and default status-word codes for the
// access permission checker. Assumes a 3-bit verdict code.
package access_guard_pkg;

    typedef enum logic [2:0] {
        VERDICT_OK     = 3'd0,
        VERDICT_ABSENT = 3'd1,
        VERDICT_RDONLY = 3'd2,
        VERDICT_KERNEL = 3'd3,
        VERDICT_NONMEM = 3'd4
    } verdict_e;

    localparam logic [15:0] STAT_ABSENT_WR = 16'h8FFF;
    localparam logic [15:0] STAT_ABSENT_RD = 16'hCFFF;
    localparam logic [15:0] STAT_NONMEM_WR = 16'h9EFF;
    localparam logic [15:0] STAT_NONMEM_RD = 16'hDEFF;
    localparam logic [15:0] STAT_RESET     = 16'hFFFF;

endpackage

// File: rtl/access_guard_classify.sv
// Module: access_guard_classify
// Purely combinational judgement of one access. Applies the fault causes in
// fixed priority: outside window, page absent, kernel region, write enable.
// Assumes the address field bounds and map-word bit positions given by the
// parameters lie inside the port widths.
module access_guard_classify
    import access_guard_pkg::*;
#(
    parameter int ADDR_W          = 24,
    parameter int MAP_W           = 16,
    parameter int WINDOW_BIT      = 22,
    parameter int KERN_LO         = 19,
    parameter int KERN_HI         = 22,
    parameter int PRES_LO         = 13,
    parameter int PRES_HI         = 14,
    parameter int WEN_BIT         = 15,
    parameter bit WP_CHECKS_READS = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              is_super,
    input  logic [MAP_W-1:0]  map_word,
    output verdict_e          verdict_c
);

    localparam int WIN_BITS  = ADDR_W - WINDOW_BIT;
    localparam int KERN_BITS = KERN_HI - KERN_LO + 1;
    localparam int PRES_BITS = PRES_HI - PRES_LO + 1;

    logic outside_window;
    logic page_absent;
    logic kernel_hit;
    logic wen_clear;
    logic wp_applies;

    // Individual cause detectors on their own fields.
    always_comb begin
        outside_window = |addr[ADDR_W-1 -: WIN_BITS];
        page_absent    = (map_word[PRES_HI -: PRES_BITS] == '0);
        kernel_hit     = (addr[KERN_HI -: KERN_BITS] == '0);
        wen_clear      = ~map_word[WEN_BIT];
    end

    // Variant choice: does the write-enable check cover reads as well.
    generate
        if (WP_CHECKS_READS) begin : g_wp_all
            assign wp_applies = wen_clear;
        end else begin : g_wp_writes
            assign wp_applies = wen_clear & is_write;
        end
    endgenerate

    // Priority selection of the first cause that applies.
    always_comb begin
        if (is_super)            verdict_c = VERDICT_OK;
        else if (outside_window) verdict_c = VERDICT_NONMEM;
        else if (page_absent)    verdict_c = VERDICT_ABSENT;
        else if (kernel_hit)     verdict_c = VERDICT_KERNEL;
        else if (wp_applies)     verdict_c = VERDICT_RDONLY;
        else                     verdict_c = VERDICT_OK;
    end

    // Fold the fields this stage does not decode so every bit is consumed.
    logic unused_fields;
    assign unused_fields = ^{addr, map_word};

endmodule

// File: rtl/access_guard_status.sv
// Module: access_guard_status
// Combinational next value of the general-status word. Only the absent and
// outside-window verdicts load a code, chosen by access direction; every
// other verdict, or no access, keeps the current word.
module access_guard_status
    import access_guard_pkg::*;
#(
    parameter int          STAT_W    = 16,
    parameter logic [15:0] ABSENT_WR = STAT_ABSENT_WR,
    parameter logic [15:0] ABSENT_RD = STAT_ABSENT_RD,
    parameter logic [15:0] NONMEM_WR = STAT_NONMEM_WR,
    parameter logic [15:0] NONMEM_RD = STAT_NONMEM_RD
) (
    input  logic              valid,
    input  logic              is_write,
    input  verdict_e          verdict_c,
    input  logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] status_d
);

    // Select the code to load, or hold.
    always_comb begin
        status_d = status_q;
        if (valid) begin
            unique case (verdict_c)
                VERDICT_ABSENT: status_d = is_write ? ABSENT_WR[STAT_W-1:0] : ABSENT_RD[STAT_W-1:0];
                VERDICT_NONMEM: status_d = is_write ? NONMEM_WR[STAT_W-1:0] : NONMEM_RD[STAT_W-1:0];
                default:        status_d = status_q;
            endcase
        end
    end

endmodule

// File: rtl/access_guard_resp.sv
// Module: access_guard_resp
// Output register stage: bus-error pulse, verdict, status word and returned
// read data, all updated on the same edge. Synchronous active-low reset.
module access_guard_resp
    import access_guard_pkg::*;
#(
    parameter int          STAT_W    = 16,
    parameter int          DATA_W    = 32,
    parameter logic [15:0] STAT_INIT = STAT_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              is_write,
    input  verdict_e          verdict_c,
    input  logic [STAT_W-1:0] status_d,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              err_q,
    output verdict_e          verdict_q,
    output logic [STAT_W-1:0] status_q,
    output logic [DATA_W-1:0] rd_data_q
);

    logic faulted;
    assign faulted = (verdict_c != VERDICT_OK);

    // Verdict and error pulse: live for one cycle after each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            verdict_q <= VERDICT_OK;
        end else if (valid) begin
            err_q     <= faulted;
            verdict_q <= verdict_c;
        end else begin
            err_q     <= 1'b0;
            verdict_q <= VERDICT_OK;
        end
    end

    // General-status word: takes the next value prepared upstream.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= STAT_INIT[STAT_W-1:0];
        else        status_q <= status_d;
    end

    // Returned read data: all ones on a faulted read, pass-through otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rd_data_q <= '0;
        else if (valid && !is_write)   rd_data_q <= faulted ? '1 : rd_data_in;
    end

endmodule

// File: rtl/access_guard.sv
// Module: access_guard (top)
// Judges each bus access against supervisor state, the memory window, the
// kernel region and the page-map word, and reports the result one clock
// later. Assumes the map word supplied is the one for the addressed page;
// translation itself happens elsewhere.
module access_guard
    import access_guard_pkg::*;
#(
    parameter int ADDR_W          = 24,
    parameter int MAP_W           = 16,
    parameter int DATA_W          = 32,
    parameter int STAT_W          = 16,
    parameter int WINDOW_BIT      = 22,
    parameter int KERN_LO         = 19,
    parameter int KERN_HI         = 22,
    parameter int PRES_LO         = 13,
    parameter int PRES_HI         = 14,
    parameter int WEN_BIT         = 15,
    parameter bit WP_CHECKS_READS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              cpu_super,
    input  logic [MAP_W-1:0]  map_entry,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              bus_err,
    output logic [2:0]        verdict,
    output logic [STAT_W-1:0] gen_status,
    output logic [DATA_W-1:0] rd_data_out
);

    verdict_e          verdict_c;
    verdict_e          verdict_q;
    logic [STAT_W-1:0] status_d;
    logic [STAT_W-1:0] status_q;

    access_guard_classify #(
        .ADDR_W(ADDR_W), .MAP_W(MAP_W), .WINDOW_BIT(WINDOW_BIT),
        .KERN_LO(KERN_LO), .KERN_HI(KERN_HI), .PRES_LO(PRES_LO),
        .PRES_HI(PRES_HI), .WEN_BIT(WEN_BIT), .WP_CHECKS_READS(WP_CHECKS_READS)
    ) classify_i (
        .addr(acc_addr), .is_write(acc_write), .is_super(cpu_super),
        .map_word(map_entry), .verdict_c(verdict_c)
    );

    access_guard_status #(.STAT_W(STAT_W)) status_i (
        .valid(acc_valid), .is_write(acc_write), .verdict_c(verdict_c),
        .status_q(status_q), .status_d(status_d)
    );

    access_guard_resp #(.STAT_W(STAT_W), .DATA_W(DATA_W)) resp_i (
        .clk(clk), .rst_n(rst_n), .valid(acc_valid), .is_write(acc_write),
        .verdict_c(verdict_c), .status_d(status_d), .rd_data_in(rd_data_in),
        .err_q(bus_err), .verdict_q(verdict_q), .status_q(status_q),
        .rd_data_q(rd_data_out)
    );

    assign verdict    = verdict_q;
    assign gen_status = status_q;

endmodule

// File: rtl/access_guard_chk.sv
// Module: access_guard_chk
// Port-level temporal checks for access_guard, attached through bind.
module access_guard_chk #(
    parameter int ADDR_W = 24,
    parameter int MAP_W  = 16,
    parameter int DATA_W = 32,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              cpu_super,
    input logic [MAP_W-1:0]  map_entry,
    input logic              bus_err,
    input logic [2:0]        verdict,
    input logic [STAT_W-1:0] gen_status,
    input logic [DATA_W-1:0] rd_data_out
);

    logic user_acc;
    logic below_win;
    assign user_acc  = acc_valid && !cpu_super;
    assign below_win = (acc_addr < 24'h400000);

    assert_super_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && cpu_super |=> (verdict == 3'd0) && !bus_err);

    assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc && !below_win |=> verdict == 3'd4);

    assert_absent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc && below_win && (map_entry[14:13] == 2'b00) |=> verdict == 3'd1);

    assert_absent_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc && below_win && (map_entry[14:13] == 2'b00)
        |=> gen_status == ($past(acc_write) ? 16'h8FFF : 16'hCFFF));

    assert_window_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        user_acc && !below_win
        |=> gen_status == ($past(acc_write) ? 16'h9EFF : 16'hDEFF));

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid || cpu_super || (below_win && map_entry[14:13] != 2'b00)
        |=> $stable(gen_status));

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> verdict != 3'd0);

    assert_verdict_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        verdict <= 3'd4);

    assert_fault_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> !bus_err || (rd_data_out == '1));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !bus_err && $stable(rd_data_out));

endmodule

bind access_guard access_guard_chk #(
    .ADDR_W(ADDR_W), .MAP_W(MAP_W), .DATA_W(DATA_W), .STAT_W(STAT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .cpu_super(cpu_super), .map_entry(map_entry),
    .bus_err(bus_err), .verdict(verdict), .gen_status(gen_status),
    .rd_data_out(rd_data_out)
);

// File: tb/access_guard_tb_top.sv
// Bench: two copies of access_guard (write-enable check on reads enabled and
// disabled) against a behavioural model, compared on every falling edge.
module access_guard_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        acc_valid;
    logic [23:0] acc_addr;
    logic        acc_write;
    logic        cpu_super;
    logic [15:0] map_entry;
    logic [31:0] rd_data_in;

    logic        err_a, err_b;
    logic [2:0]  ver_a, ver_b;
    logic [15:0] st_a, st_b;
    logic [31:0] rd_a, rd_b;

    access_guard #(.WP_CHECKS_READS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .cpu_super(cpu_super), .map_entry(map_entry),
        .rd_data_in(rd_data_in), .bus_err(err_a), .verdict(ver_a),
        .gen_status(st_a), .rd_data_out(rd_a)
    );

    access_guard #(.WP_CHECKS_READS(1'b0)) dut_wr_only_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .cpu_super(cpu_super), .map_entry(map_entry),
        .rd_data_in(rd_data_in), .bus_err(err_b), .verdict(ver_b),
        .gen_status(st_b), .rd_data_out(rd_b)
    );

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 1'b0;
    int          exp_ver [2];
    bit          exp_err [2];
    logic [15:0] exp_st  [2];
    logic [31:0] exp_rd  [2];
    string       pend_tag = "R11";

    // Reference verdict from the requirement text.
    function automatic int ref_verdict(bit sup, logic [23:0] a, bit wr,
                                       logic [15:0] m, bit wp_reads);
        if (sup) return 0;
        if (a >= 24'h400000) return 4;
        if (m[14:13] == 2'b00) return 1;
        if (a[22:19] == 4'd0) return 3;
        if (!m[15] && (wr || wp_reads)) return 2;
        return 0;
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "err[rd+wr]",  err_a, exp_err[0]);
        check(tag, "ver[rd+wr]",  ver_a, exp_ver[0]);
        check(tag, "stat[rd+wr]", st_a,  exp_st[0]);
        check(tag, "rd[rd+wr]",   rd_a,  exp_rd[0]);
        check(tag, "err[wr]",     err_b, exp_err[1]);
        check(tag, "ver[wr]",     ver_b, exp_ver[1]);
        check(tag, "stat[wr]",    st_b,  exp_st[1]);
        check(tag, "rd[wr]",      rd_b,  exp_rd[1]);
    endtask

    // One access: check the previous result, drive, advance the model.
    task automatic step(bit v, logic [23:0] a, bit wr, bit sup,
                        logic [15:0] m, logic [31:0] d, string tag);
        @(negedge clk);
        compare_all(pend_tag);
        acc_valid = v; acc_addr = a; acc_write = wr;
        cpu_super = sup; map_entry = m; rd_data_in = d;
        for (int i = 0; i < 2; i++) begin
            if (v) begin
                int code;
                code = ref_verdict(sup, a, wr, m, (i == 0));
                exp_ver[i] = code;
                exp_err[i] = (code != 0);
                if (code == 1) exp_st[i] = wr ? 16'h8FFF : 16'hCFFF;
                if (code == 4) exp_st[i] = wr ? 16'h9EFF : 16'hDEFF;
                if (!wr) exp_rd[i] = (code != 0) ? 32'hFFFF_FFFF : d;
            end else begin
                exp_ver[i] = 0;
                exp_err[i] = 1'b0;
            end
        end
        pend_tag = tag;
    endtask

    localparam logic [15:0] M_OK  = 16'hE005;
    localparam logic [15:0] M_RO  = 16'h6005;
    localparam logic [15:0] M_ABS = 16'h8005;

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0;
        cpu_super = 1'b0; map_entry = '0; rd_data_in = '0;
        for (int i = 0; i < 2; i++) begin
            exp_ver[i] = 0; exp_err[i] = 1'b0;
            exp_st[i] = 16'hFFFF; exp_rd[i] = '0;
        end
        repeat (3) @(negedge clk);
        compare_all("R11");
        rst_n = 1'b1;
        // R1: supervisor passes even out of window with an absent page
        step(1, 24'h500000, 1, 1, M_ABS, 32'h0, "R1");
        step(1, 24'h010000, 0, 1, M_ABS, 32'hA5A5_0001, "R1");
        // R2 R7: out-of-window read and write codes, boundary address
        step(1, 24'h500000, 0, 0, M_OK, 32'h1, "R2/R7/R10");
        step(1, 24'h400000, 1, 0, M_ABS, 32'h1, "R2/R7");
        // R3 R6: absent page just below window, then kernel + absent
        step(1, 24'h3FFFFF, 1, 0, M_ABS, 32'h1, "R3/R6");
        step(1, 24'h010000, 0, 0, M_ABS, 32'h2, "R3/R6/R10");
        // R4 R8: kernel beats write-protect; status untouched
        step(1, 24'h010000, 1, 0, M_RO, 32'h3, "R4/R8");
        // R5: write-protect write; then read differs between variants
        step(1, 24'h080000, 1, 0, M_RO, 32'h4, "R5/R8");
        step(1, 24'h080000, 0, 0, M_RO, 32'hBEEF_0005, "R5/R10");
        // R10: allowed read passes data; R12 idle holds everything
        step(1, 24'h080000, 0, 0, M_OK, 32'h1234_5678, "R10");
        step(0, 24'h500000, 0, 0, M_ABS, 32'h9, "R12");
        step(0, 24'h000000, 1, 0, M_ABS, 32'h9, "R12");
        // R9: back-to-back faults then an allowed write
        step(1, 24'h600000, 0, 0, M_OK, 32'h7, "R9");
        step(1, 24'h080000, 1, 0, M_ABS, 32'h7, "R9");
        step(1, 24'h080000, 1, 0, M_OK, 32'h7, "R9/R8");
        // randomized mix over the same causes
        for (int k = 0; k < 400; k++) begin
            logic [23:0] a;
            logic [15:0] m;
            case ($urandom % 4)
                0: a = 24'h400000 | 24'($urandom % 24'h400000) | 24'h800000 * ($urandom % 2);
                1: a = 24'($urandom % 24'h080000);
                2: a = 24'h080000 + 24'($urandom % 24'h380000);
                default: a = 24'h3FFFFF;
            endcase
            m = 16'($urandom);
            step(($urandom % 5) != 0, a, $urandom % 2, ($urandom % 6) == 0,
                 m, 32'($urandom), "R1/R2/R3/R4/R5/R9");
        end
        @(negedge clk);
        compare_all(pend_tag);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R9 actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule